// File: doc/BRIEF.md
# Multi-Mode Serial Shift Register

This block is the serial byte port of a peripheral-interface chip. An 8-bit register moves data in or out through a data pin (CB2), paced by a clock pin (CB1). A 3-bit mode field picks the direction and the pacing source. The pace can come from the timeouts of an interval timer, from the system clock, or from pulses that another device puts on CB1. In the internally paced modes the block produces the CB1 pulses itself. In the externally paced modes it watches CB1 through a synchroniser.

The CPU side is a plain register interface with no back-pressure. A write strobe loads the register. A read strobe marks a read. `rdata` always shows the current register contents. Either strobe counts as an access. An access clears the completion flag, reloads the 8-pulse counter and, in the internally paced modes, starts a new byte. The timer's timeout pulse and its low-byte latch value N arrive as inputs. The completion flag is a level output that the CPU can poll.

Top module: `ser_shift_unit`

## Requirements
- R1: After reset the register reads 0x00, `irq_flag` is 0, `cb1_out` is 1 and `cb2_out` is 1.
- R2: `cb1_oe` is 1 in modes 1, 2, 4, 5 and 6 and 0 otherwise. `cb2_oe` is 1 in modes 4 to 7 and 0 otherwise.
- R3: When shifting in (modes 0 to 3), each shift moves the register up one place and puts the CB2 input into bit 0. After 8 shifts the first bit received is in bit 7.
- R4: When shifting out (modes 4 to 7), each shift drives bit 7 onto `cb2_out` and rotates the register left, with bit 7 going into bit 0. The MSB therefore leaves first, and after 8 shifts the register again holds the byte that was loaded. Between shifts `cb2_out` holds its level.
- R5: While running, the generated CB1 toggles every N+2 system clocks in modes 1, 4 and 5, and every clock in modes 2 and 6. Each low-to-high transition of CB1 is one shift.
- R6: In modes 1, 4 and 5, an access made while the flag is clear arms the block but produces no CB1 pulse until the next timer timeout. An access made while the flag is set starts shifting at once, with no timeout.
- R7: In modes 1, 2, 5 and 6, shifting stops after exactly 8 CB1 rising edges. The flag then sets and CB1 returns to its high idle level.
- R8: In modes 3 and 7, the external CB1 passes through a two-flop synchroniser, and each rising edge shifts once. The flag sets on every 8th edge, and shifting continues past it.
- R9: Mode 4 recirculates the byte without end and never sets the flag.
- R10: Mode 0 shifts CB2 in on each external CB1 rising edge, and the flag is held at 0.
- R11: A read or write access clears the flag and restarts the 8-pulse count. A write loads the register with `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Operating mode 0..7 |
| sr_wr | input | 1 | Register write strobe (one cycle) |
| sr_rd | input | 1 | Register read strobe (one cycle) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Current register contents |
| tmr_tick | input | 1 | Interval timer timeout pulse |
| tmr_n | input | 8 | Timer low-byte latch value N |
| cb1_in | input | 1 | External clock pin input |
| cb1_out | output | 1 | Generated clock pin value |
| cb1_oe | output | 1 | Clock pin output enable |
| cb2_in | input | 1 | Serial data pin input |
| cb2_out | output | 1 | Serial data pin output value |
| cb2_oe | output | 1 | Data pin output enable |
| irq_flag | output | 1 | Byte-complete flag, level |

## Verification
Suppose the 8-pulse counter holds a wrong value. In the stopping modes the byte then ends with a pulse count other than 8 on `cb1_out`. In the external modes the flag rises on the wrong edge. Both show within one byte time. A wrong half-period reload shows up as a wrong spacing of the CB1 transitions on the very first pulse. If the pacing state is wrong (armed versus running), CB1 either moves before a timer timeout or never moves, which is visible within N+2 clocks. A wrong shift or rotation path corrupts the `cb2_out` sequence or the `rdata` readback at the end of the byte.

// File: rtl/ser_shift_pkg.sv
`timescale 1ns/1ps
package ser_shift_pkg;

  typedef enum logic [2:0] {
    SM_OFF      = 3'd0,
    SM_IN_TMR   = 3'd1,
    SM_IN_SYS   = 3'd2,
    SM_IN_EXT   = 3'd3,
    SM_OUT_LOOP = 3'd4,
    SM_OUT_TMR  = 3'd5,
    SM_OUT_SYS  = 3'd6,
    SM_OUT_EXT  = 3'd7
  } sm_mode_e;

  typedef enum logic [1:0] {
    PG_IDLE  = 2'd0,
    PG_ARMED = 2'd1,
    PG_RUN   = 2'd2
  } pg_state_e;

  // block drives CB1 itself
  function automatic logic is_internal(sm_mode_e m);
    return m inside {SM_IN_TMR, SM_IN_SYS, SM_OUT_LOOP, SM_OUT_TMR, SM_OUT_SYS};
  endfunction

  // pace comes from timer timeouts
  function automatic logic is_timer(sm_mode_e m);
    return m inside {SM_IN_TMR, SM_OUT_LOOP, SM_OUT_TMR};
  endfunction

  // shifts follow edges seen on the CB1 input
  function automatic logic is_external(sm_mode_e m);
    return m inside {SM_OFF, SM_IN_EXT, SM_OUT_EXT};
  endfunction

  // 8-pulse counter active
  function automatic logic is_counted(sm_mode_e m);
    return !(m inside {SM_OFF, SM_OUT_LOOP});
  endfunction

  // byte end halts the pulse generator
  function automatic logic is_stopping(sm_mode_e m);
    return m inside {SM_IN_TMR, SM_IN_SYS, SM_OUT_TMR, SM_OUT_SYS};
  endfunction

endpackage

// File: rtl/ser_pin_sync.sv
`timescale 1ns/1ps
module ser_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);

  // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/ser_bit_counter.sv
`timescale 1ns/1ps
module ser_bit_counter #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic shift,
  input  logic counting,
  output logic last
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] FULL = CW'(WIDTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= FULL;
    else if (reload)            cnt <= FULL;
    else if (shift && counting) cnt <= (cnt == ONE) ? FULL : cnt - ONE;
  end

  assign last = shift && counting && (cnt == ONE);

  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && (cnt <= FULL));

  // R11
  reload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == FULL));

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !reload) |=> (cnt == FULL));

endmodule

// File: rtl/ser_pulse_gen.sv
`timescale 1ns/1ps
module ser_pulse_gen
  import ser_shift_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          timer_paced,
  input  logic          access,
  input  logic          flag_now,
  input  logic          tick,
  input  logic [TW-1:0] n_val,
  input  logic          stop_req,
  output logic          cb1_q,
  output logic          shift_evt
);

  localparam int HW = TW + 1;

  pg_state_e     state;
  logic [HW-1:0] hcnt;
  logic [HW-1:0] reload;

  // half period minus one: N+1 for timer pacing, 0 for system pacing
  assign reload = timer_paced ? (HW'(n_val) + HW'(1)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PG_IDLE;
      hcnt  <= '0;
      cb1_q <= 1'b1;
    end else if (!enable) begin
      state <= PG_IDLE;
      hcnt  <= '0;
      cb1_q <= 1'b1;
    end else if (access) begin
      state <= (timer_paced && !flag_now) ? PG_ARMED : PG_RUN;
      hcnt  <= reload;
      cb1_q <= 1'b1;
    end else begin
      unique case (state)
        PG_ARMED: begin
          if (tick) begin
            state <= PG_RUN;
            hcnt  <= reload;
          end
        end
        PG_RUN: begin
          if (hcnt == '0) begin
            cb1_q <= ~cb1_q;
            hcnt  <= reload;
            if (!cb1_q && stop_req) state <= PG_IDLE;
          end else begin
            hcnt <= hcnt - HW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign shift_evt = enable && !access && (state == PG_RUN) &&
                     (hcnt == '0) && !cb1_q;

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PG_RUN) |-> cb1_q);

  // R6
  armed_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_ARMED && enable && !tick && !access) |=>
      (state == PG_ARMED && cb1_q));

  // R5
  edge_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_RUN && enable && !access && hcnt != '0) |=> $stable(cb1_q));

endmodule

// File: rtl/ser_data_reg.sv
`timescale 1ns/1ps
module ser_data_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  input  logic             dir_out,
  input  logic             serial_in,
  output logic [WIDTH-1:0] data,
  output logic             ser_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data    <= '0;
      ser_out <= 1'b1;
    end else if (load) begin
      data <= load_val;
    end else if (shift) begin
      if (dir_out) begin
        ser_out <= data[WIDTH-1];
        data    <= {data[WIDTH-2:0], data[WIDTH-1]};
      end else begin
        data <= {data[WIDTH-2:0], serial_in};
      end
    end
  end

  // R4
  out_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && dir_out && !load) |=>
      (ser_out == $past(data[WIDTH-1]) && data[0] == $past(data[WIDTH-1])));

  // R3
  in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !dir_out && !load) |=> (data[0] == $past(serial_in)));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift && dir_out) |=> $stable(ser_out));

endmodule

// File: rtl/ser_shift_unit.sv
`timescale 1ns/1ps
module ser_shift_unit
  import ser_shift_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int TW    = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             sr_wr,
  input  logic             sr_rd,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             tmr_tick,
  input  logic [TW-1:0]    tmr_n,
  input  logic             cb1_in,
  output logic             cb1_out,
  output logic             cb1_oe,
  input  logic             cb2_in,
  output logic             cb2_out,
  output logic             cb2_oe,
  output logic             irq_flag
);

  sm_mode_e m;
  logic access, int_clk, tmr_paced, ext_clk, counted, stopping, dir_out;
  logic ext_rise, gen_evt, shift_evt, last, stop_req, irq_q;

  assign m         = sm_mode_e'(mode);
  assign access    = sr_wr | sr_rd;
  assign int_clk   = is_internal(m);
  assign tmr_paced = is_timer(m);
  assign ext_clk   = is_external(m);
  assign counted   = is_counted(m);
  assign stopping  = is_stopping(m);
  assign dir_out   = mode[2];

  ser_pin_sync #(.STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (cb1_in),
    .rise (ext_rise)
  );

  assign shift_evt = int_clk ? gen_evt : (ext_clk && ext_rise && !access);

  ser_bit_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (access),
    .shift   (shift_evt),
    .counting(counted),
    .last    (last)
  );

  assign stop_req = last && stopping;

  ser_pulse_gen #(.TW(TW)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (int_clk),
    .timer_paced(tmr_paced),
    .access     (access),
    .flag_now   (irq_q),
    .tick       (tmr_tick),
    .n_val      (tmr_n),
    .stop_req   (stop_req),
    .cb1_q      (cb1_out),
    .shift_evt  (gen_evt)
  );

  ser_data_reg #(.WIDTH(WIDTH)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sr_wr),
    .load_val (wdata),
    .shift    (shift_evt),
    .dir_out  (dir_out),
    .serial_in(cb2_in),
    .data     (rdata),
    .ser_out  (cb2_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             irq_q <= 1'b0;
    else if (m == SM_OFF)   irq_q <= 1'b0;
    else if (access)        irq_q <= 1'b0;
    else if (last)          irq_q <= 1'b1;
  end

  assign irq_flag = irq_q;
  assign cb1_oe   = int_clk;
  assign cb2_oe   = dir_out;

  // R10
  off_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |=> !irq_flag);

  // R11
  access_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr || sr_rd) |=> !irq_flag);

  // R9
  loop_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !irq_flag) |=> !irq_flag);

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !access) |=> (cb1_out && irq_flag));

endmodule

// File: tb/test_ser_shift_unit.sv
`timescale 1ns/1ps
module test_ser_shift_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       sr_wr = 1'b0, sr_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tmr_tick = 1'b0;
  logic [7:0] tmr_n = 8'h00;
  logic       cb1_in = 1'b1, cb2_in = 1'b0;
  logic       cb1_out, cb1_oe, cb2_out, cb2_oe, irq_flag;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ser_shift_unit i_ser_shift_unit (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sr_wr(sr_wr), .sr_rd(sr_rd),
    .wdata(wdata), .rdata(rdata), .tmr_tick(tmr_tick), .tmr_n(tmr_n),
    .cb1_in(cb1_in), .cb1_out(cb1_out), .cb1_oe(cb1_oe),
    .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe), .irq_flag(irq_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); sr_wr = 1'b1; wdata = v;
    @(negedge clk); sr_wr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); sr_rd = 1'b1;
    @(negedge clk); sr_rd = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tmr_tick = 1'b1;
    @(negedge clk); tmr_tick = 1'b0;
  endtask

  task automatic clear_flag_via_off(input logic [2:0] next_mode);
    @(negedge clk); mode = 3'd0;
    repeat (2) @(negedge clk);
    mode = next_mode;
    @(negedge clk);
  endtask

  // observe generated CB1 for a window; feed/check CB2 per rising edge
  task automatic run_gen(input logic [7:0] pat, input logic out_dir,
                         input int window, output int rises,
                         output int interval, output int out_bad);
    logic prev;
    int tf, tr;
    rises = 0; out_bad = 0; tf = -1; tr = -1;
    prev = cb1_out;
    cb2_in = pat[7];
    for (int c = 0; c < window; c++) begin
      @(negedge clk);
      if (prev && !cb1_out && tf < 0) tf = c;
      if (!prev && cb1_out) begin
        if (tr < 0) tr = c;
        if (out_dir && cb2_out != pat[7 - (rises % 8)]) out_bad++;
        rises++;
        cb2_in = pat[7 - (rises % 8)];
      end
      prev = cb1_out;
    end
    interval = tr - tf;
  endtask

  task automatic ext_pulse(input logic b);
    @(negedge clk); cb2_in = b; cb1_in = 1'b0;
    repeat (4) @(negedge clk);
    cb1_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pats [3];
    int n_vals [3];
    logic [2:0] gmodes [4];
    int rises, interval, out_bad, lows, ivl, win;
    logic [7:0] exp_sr;
    logic timer, outd;

    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h81;
    n_vals[0] = 0; n_vals[1] = 1; n_vals[2] = 3;
    gmodes[0] = 3'd1; gmodes[1] = 3'd2; gmodes[2] = 3'd5; gmodes[3] = 3'd6;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rdata", int'(rdata), 8'h00);
    chk("R1", "irq_flag", int'(irq_flag), 0);
    chk("R1", "cb1_out", int'(cb1_out), 1);
    chk("R1", "cb2_out", int'(cb2_out), 1);

    // R2 pin directions in every mode
    for (int md = 0; md < 8; md++) begin
      @(negedge clk); mode = 3'(md);
      @(negedge clk);
      chk("R2", "cb1_oe", int'(cb1_oe), (md inside {1, 2, 4, 5, 6}) ? 1 : 0);
      chk("R2", "cb2_oe", int'(cb2_oe), (md >= 4) ? 1 : 0);
    end

    // R3 R4 R5 R6 R7 internally paced byte transfers
    for (int gi = 0; gi < 4; gi++) begin
      for (int ni = 0; ni < 3; ni++) begin
        for (int pi = 0; pi < 3; pi++) begin
          timer = (gmodes[gi] == 3'd1 || gmodes[gi] == 3'd5);
          outd  = gmodes[gi][2];
          tmr_n = 8'(n_vals[ni]);
          ivl   = timer ? n_vals[ni] + 2 : 1;
          win   = 16 * ivl + 20;
          clear_flag_via_off(gmodes[gi]);
          do_write(outd ? pats[pi] : 8'h00);
          if (timer) begin
            lows = 0;
            for (int c = 0; c < 10; c++) begin
              @(negedge clk);
              if (!cb1_out) lows++;
            end
            // R6 no pulse before timeout
            chk("R6", "cb1 low before timeout", lows, 0);
            pulse_tick();
          end
          run_gen(pats[pi], outd, win, rises, interval, out_bad);
          chk("R7", "cb1 rising edges", rises, 8);
          chk("R5", "cb1 half period", interval, ivl);
          chk(outd ? "R4" : "R3", "rdata after byte", int'(rdata), int'(pats[pi]));
          chk("R7", "irq_flag after byte", int'(irq_flag), 1);
          chk("R7", "cb1 idle", int'(cb1_out), 1);
          if (outd) begin
            chk("R4", "cb2 bit order", out_bad, 0);
            chk("R4", "cb2 holds last bit", int'(cb2_out), int'(pats[pi][0]));
          end
          if (timer) begin
            // R6 flag set: access starts at once, no timeout supplied
            do_read();
            run_gen(pats[pi], outd, win, rises, interval, out_bad);
            chk("R6", "immediate restart edges", rises, 8);
            chk(outd ? "R4" : "R3", "rdata after restart", int'(rdata), int'(pats[pi]));
            if (outd) chk("R4", "cb2 order on restart", out_bad, 0);
          end
        end
      end
    end

    // R9 free-running recirculation
    for (int pi = 0; pi < 3; pi++) begin
      tmr_n = 8'd1;
      clear_flag_via_off(3'd4);
      do_write(pats[pi]);
      lows = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (!cb1_out) lows++;
      end
      chk("R6", "mode4 waits for timeout", lows, 0);
      pulse_tick();
      run_gen(pats[pi], 1'b1, 200, rises, interval, out_bad);
      chk("R9", "mode4 keeps running", int'(rises >= 9), 1);
      chk("R9", "mode4 flag stays clear", int'(irq_flag), 0);
      chk("R9", "mode4 cb2 sequence", out_bad, 0);
    end

    // R8 R3 R11 external shift in, mode 3
    for (int pi = 0; pi < 3; pi++) begin
      clear_flag_via_off(3'd3);
      do_write(8'h00);
      exp_sr = 8'h00;
      for (int k = 0; k < 8; k++) begin
        ext_pulse(pats[pi][7 - k]);
        exp_sr = {exp_sr[6:0], pats[pi][7 - k]};
        if (k == 6) chk("R8", "flag before 8th edge", int'(irq_flag), 0);
      end
      chk("R8", "flag on 8th edge", int'(irq_flag), 1);
      chk("R3", "mode3 byte", int'(rdata), int'(pats[pi]));
      for (int k = 0; k < 3; k++) begin
        ext_pulse(k[0]);
        exp_sr = {exp_sr[6:0], k[0]};
      end
      chk("R8", "shifting continues", int'(rdata), int'(exp_sr));
      chk("R8", "flag held past 8", int'(irq_flag), 1);
      do_read();
      chk("R11", "read clears flag", int'(irq_flag), 0);
      for (int k = 0; k < 8; k++) ext_pulse(1'b1);
      chk("R11", "count restarted by read", int'(irq_flag), 1);
    end

    // R8 R4 external shift out, mode 7
    for (int pi = 0; pi < 3; pi++) begin
      clear_flag_via_off(3'd7);
      do_write(pats[pi]);
      for (int k = 0; k < 8; k++) begin
        ext_pulse(1'b0);
        chk("R4", "mode7 cb2 bit", int'(cb2_out), int'(pats[pi][7 - k]));
      end
      chk("R8", "mode7 flag", int'(irq_flag), 1);
      chk("R4", "mode7 rotated back", int'(rdata), int'(pats[pi]));
      ext_pulse(1'b0);
      chk("R8", "mode7 continues", int'(cb2_out), int'(pats[pi][7]));
    end

    // R10 R11 mode 0
    for (int pi = 0; pi < 3; pi++) begin
      @(negedge clk); mode = 3'd0;
      do_write(pats[pi]);
      chk("R11", "write loads", int'(rdata), int'(pats[pi]));
      exp_sr = pats[pi];
      for (int k = 0; k < 10; k++) begin
        ext_pulse(pats[pi][k % 8] ^ 1'b1);
        exp_sr = {exp_sr[6:0], pats[pi][k % 8] ^ 1'b1};
      end
      chk("R10", "mode0 shifts in", int'(rdata), int'(exp_sr));
      chk("R10", "mode0 flag held low", int'(irq_flag), 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule